// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This engine moves data between a word-wide memory port and a card data FIFO. It takes its work from a list of descriptors in memory. Each descriptor is four 32-bit words. Software builds the list, programs the list base, and starts the engine with one write to the control register. The engine fetches each descriptor and checks its ownership and alignment. It then moves the segment one word per memory grant, and hands the descriptor back by rewriting its config word with the ownership bit cleared. A descriptor can point to its successor through its fourth word, or its successor can sit directly after it in memory. The walk ends at the descriptor marked last.

A completion status bit is raised when a descriptor whose interrupt-suppress flag is clear has been written back. Two error bits report a descriptor the engine does not own and a misaligned buffer or length. Software clears each status bit by writing 1 to it. The interrupt line is the OR of the status bits that are enabled in the interrupt-enable register. The card-to-memory direction is selected in the control register. Software normally enables the completion interrupt only for that direction.

Top module: `dmaChainEngine`

## Requirements
- R1: After reset, memReq and irq are low, and the control, status and interrupt-enable registers read 0.
- R2: While the engine is idle, a write to the control register (index 0) with enable (bit 2) set and soft reset (bit 0) clear starts a walk. The walk begins by reading the descriptor at the list base (index 1) in word order: config at +0, size at +4, buffer address at +8, next pointer at +12.
- R3: In the config word, bit 31 is ownership, bit 4 chained, bit 3 first, bit 2 last and bit 1 interrupt-suppress. A fetched descriptor with bit 31 clear stops the engine and sets status bit 1. No data is moved and no write-back is made.
- R4: With control bit 3 set, FIFO words are written to consecutive buffer addresses. With it clear, words are read from consecutive buffer addresses and pushed into the FIFO in the same order.
- R5: Only the low SIZE_BITS bits of the size word count, and the segment holds that many bytes, 4 per word. A value of 0 there means 2^SIZE_BITS bytes.
- R6: A buffer address or length whose two low bits are not zero stops the engine and sets status bit 2. No data is moved and the descriptor is not rewritten.
- R7: After its segment, the descriptor's config word is rewritten at its own address with bit 31 cleared and all other bits unchanged.
- R8: The next descriptor comes from word 3 when the chained bit is set, and from the current address plus 16 otherwise. The walk ends after the write-back of a descriptor with the last bit set, and control bit 2 then reads 0. Control bit 1 (fixed burst) reads back as written.
- R9: Status bit 0 is set on the write-back of a descriptor whose interrupt-suppress bit is clear, and is not set by one whose bit is set.
- R10: Writing 1 to a status bit (index 2) clears it. irq is high exactly when some status bit and the matching bit of the interrupt-enable register (index 3) are both set.
- R11: Writing control bit 0 aborts any walk without further memory access and clears the enable bit, fixed burst, direction and all status bits. A later start works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low reset |
| regWe | input | 1 | register write strobe |
| regIdx | input | 2 | register index: 0 control, 1 list base, 2 status, 3 interrupt enable |
| regWdata | input | 32 | register write data |
| regRdata | output | 32 | register read data for regIdx |
| memReq | output | 1 | memory access request |
| memWe | output | 1 | request is a write |
| memAddr | output | 32 | byte address of the word |
| memWdata | output | 32 | write data |
| memGnt | input | 1 | access completes in this cycle |
| memRdata | input | 32 | read data, valid with memGnt |
| fifoWrReady | input | 1 | FIFO toward the card has room |
| fifoWrPush | output | 1 | push memRdata into the FIFO |
| fifoWrData | output | 32 | word pushed toward the card |
| fifoRdValid | input | 1 | FIFO from the card holds a word |
| fifoRdPop | output | 1 | pop the word from the card FIFO |
| fifoRdData | input | 32 | word from the card |
| irq | output | 1 | interrupt |

## Verification
The bench builds the engine with SIZE_BITS set to 6. A size field of 0 then stands for a 64-byte, 16-word segment, so the maximum-length case runs in a few dozen cycles. With this setting, a size word with high bits set (0x1F0C, 0x40) also shows directly that only the low field counts. A scoreboard predicts every memory access in order: fetches, buffer accesses and write-backs. It also predicts every FIFO push, while the memory grant stalls one cycle in four.

// File: rtl/dmaChainPkg.sv
package dmaChainPkg;
  localparam int WORD_W = 32;
  localparam int DESC_WORDS = 4;
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam int DESC_BYTES = DESC_WORDS * BYTES_PER_WORD;
  // descriptor word order (fetch order)
  localparam logic [IDX_W-1:0] W_CFG = 2'd0;
  localparam logic [IDX_W-1:0] W_SIZE = 2'd1;
  localparam logic [IDX_W-1:0] W_BUF = 2'd2;
  localparam logic [IDX_W-1:0] W_NEXT = 2'd3;
  // config word flags
  localparam int BIT_OWN = 31;
  localparam int BIT_CHAIN = 4;
  localparam int BIT_LAST = 2;
  localparam int BIT_DIC = 1;
  // register indices
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_BASE = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_IEN = 2'd3;
  // status bits
  localparam int ST_DONE = 0;
  localparam int ST_UNAVAIL = 1;
  localparam int ST_ALIGN = 2;
  localparam int ST_W = 3;

  typedef struct packed {
    logic startChain;
    logic ldWord;
    logic [IDX_W-1:0] wordIdx;
    logic selBuf;
    logic selWback;
    logic startSeg;
    logic stepWord;
    logic nextDesc;
    logic setDone;
    logic setUnavail;
    logic setAlign;
    logic stopEng;
  } ctlStrobe_t;

  typedef struct packed {
    logic goPulse;
    logic abort;
    logic dirRead;
    logic own;
    logic last;
    logic dic;
    logic misaligned;
    logic segEmpty;
  } pathFlag_t;
endpackage

// File: rtl/dmaChainCtrl.sv
module dmaChainCtrl
  import dmaChainPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pathFlag_t  flags,
  input  logic       memGnt,
  input  logic       fifoWrReady,
  input  logic       fifoRdValid,
  output logic       memReq,
  output logic       memWe,
  output logic       fifoWrPush,
  output logic       fifoRdPop,
  output ctlStrobe_t ctl
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_MOVE, S_WBACK} state_t;
  state_t state;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx <= '0;
    end else if (flags.abort) begin
      state <= S_IDLE;
      idx <= '0;
    end else begin
      case (state)
        S_IDLE: if (flags.goPulse) begin
          state <= S_FETCH;
          idx <= '0;
        end
        S_FETCH: if (memGnt) begin
          if (idx == IDX_W'(DESC_WORDS - 1)) state <= S_CHECK;
          else idx <= idx + 1'b1;
        end
        S_CHECK: state <= (!flags.own || flags.misaligned) ? S_IDLE : S_MOVE;
        S_MOVE: if (flags.segEmpty) state <= S_WBACK;
        S_WBACK: if (memGnt) begin
          state <= flags.last ? S_IDLE : S_FETCH;
          idx <= '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    memReq = 1'b0;
    memWe = 1'b0;
    fifoWrPush = 1'b0;
    fifoRdPop = 1'b0;
    case (state)
      S_IDLE: ctl.startChain = flags.goPulse;
      S_FETCH: begin
        memReq = 1'b1;
        ctl.wordIdx = idx;
        ctl.ldWord = memGnt;
      end
      S_CHECK: begin
        if (!flags.own) begin
          ctl.setUnavail = 1'b1;
          ctl.stopEng = 1'b1;
        end else if (flags.misaligned) begin
          ctl.setAlign = 1'b1;
          ctl.stopEng = 1'b1;
        end else ctl.startSeg = 1'b1;
      end
      S_MOVE: if (!flags.segEmpty) begin
        ctl.selBuf = 1'b1;
        if (flags.dirRead) begin
          memWe = 1'b1;
          memReq = fifoRdValid;
          fifoRdPop = fifoRdValid && memGnt;
        end else begin
          memReq = fifoWrReady;
          fifoWrPush = fifoWrReady && memGnt;
        end
        ctl.stepWord = memReq && memGnt;
      end
      S_WBACK: begin
        memReq = 1'b1;
        memWe = 1'b1;
        ctl.selWback = 1'b1;
        if (memGnt) begin
          ctl.setDone = !flags.dic;
          if (flags.last) ctl.stopEng = 1'b1;
          else ctl.nextDesc = 1'b1;
        end
      end
      default: ;
    endcase
    if (flags.abort) begin
      ctl = '0;
      memReq = 1'b0;
      memWe = 1'b0;
      fifoWrPush = 1'b0;
      fifoRdPop = 1'b0;
    end
  end

  AST_UNAVAIL_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && !flags.own && !flags.abort) |=> (state == S_IDLE)); // R3
endmodule

// File: rtl/dmaChainPath.sv
module dmaChainPath
  import dmaChainPkg::*;
#(
  parameter int SIZE_BITS = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regIdx,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  input  ctlStrobe_t        ctl,
  output pathFlag_t         flags,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [WORD_W-1:0] fifoRdData,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              irq
);
  localparam int CNT_W = SIZE_BITS + 1;
  localparam logic [CNT_W-1:0] MAX_SEG = {1'b1, {SIZE_BITS{1'b0}}};

  logic ctrlFixed, ctrlEnable, ctrlDir;
  logic [WORD_W-1:0] listBase, curAddr, cfgWord, bufAddr, nextAddr, bufPtr;
  logic [SIZE_BITS-1:0] sizeFld;
  logic [CNT_W-1:0] bytesLeft;
  logic [ST_W-1:0] status, intEn, setVec, clrVec;
  logic wrCtrl, softRst;

  assign wrCtrl = regWe && (regIdx == REG_CTRL);
  assign softRst = wrCtrl && regWdata[0];

  always_comb begin
    setVec = '0;
    setVec[ST_DONE] = ctl.setDone;
    setVec[ST_UNAVAIL] = ctl.setUnavail;
    setVec[ST_ALIGN] = ctl.setAlign;
    clrVec = (regWe && regIdx == REG_STAT) ? regWdata[ST_W-1:0] : '0;
  end

  // software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlFixed <= 1'b0;
      ctrlEnable <= 1'b0;
      ctrlDir <= 1'b0;
      listBase <= '0;
      status <= '0;
      intEn <= '0;
    end else if (softRst) begin
      ctrlFixed <= 1'b0;
      ctrlEnable <= 1'b0;
      ctrlDir <= 1'b0;
      status <= '0;
    end else begin
      if (wrCtrl) begin
        ctrlFixed <= regWdata[1];
        ctrlEnable <= regWdata[2];
        ctrlDir <= regWdata[3];
      end
      if (ctl.stopEng) ctrlEnable <= 1'b0;
      if (regWe && regIdx == REG_BASE) listBase <= regWdata;
      if (regWe && regIdx == REG_IEN) intEn <= regWdata[ST_W-1:0];
      status <= (status & ~clrVec) | setVec;
    end
  end

  // descriptor and segment state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      cfgWord <= '0;
      sizeFld <= '0;
      bufAddr <= '0;
      nextAddr <= '0;
      bufPtr <= '0;
      bytesLeft <= '0;
    end else begin
      if (ctl.startChain) curAddr <= listBase;
      if (ctl.nextDesc)
        curAddr <= cfgWord[BIT_CHAIN] ? nextAddr : curAddr + WORD_W'(DESC_BYTES);
      if (ctl.ldWord) begin
        case (ctl.wordIdx)
          W_CFG: cfgWord <= memRdata;
          W_SIZE: sizeFld <= memRdata[SIZE_BITS-1:0];
          W_BUF: bufAddr <= memRdata;
          W_NEXT: nextAddr <= memRdata;
          default: ;
        endcase
      end
      if (ctl.startSeg) begin
        bufPtr <= bufAddr;
        bytesLeft <= (sizeFld == '0) ? MAX_SEG : {1'b0, sizeFld};
      end
      if (ctl.stepWord) begin
        bufPtr <= bufPtr + WORD_W'(BYTES_PER_WORD);
        bytesLeft <= bytesLeft - CNT_W'(BYTES_PER_WORD);
      end
    end
  end

  always_comb begin
    flags.goPulse = wrCtrl && !regWdata[0] && regWdata[2] && !ctrlEnable;
    flags.abort = softRst;
    flags.dirRead = ctrlDir;
    flags.own = cfgWord[BIT_OWN];
    flags.last = cfgWord[BIT_LAST];
    flags.dic = cfgWord[BIT_DIC];
    flags.misaligned = (|bufAddr[1:0]) || (|sizeFld[1:0]);
    flags.segEmpty = (bytesLeft == '0);
  end

  assign memAddr = ctl.selBuf ? bufPtr : curAddr + WORD_W'({ctl.wordIdx, 2'b00});
  assign memWdata = ctl.selWback ? (cfgWord & ~(WORD_W'(1) << BIT_OWN)) : fifoRdData;
  assign irq = |(status & intEn);

  always_comb begin
    case (regIdx)
      REG_CTRL: regRdata = WORD_W'({ctrlDir, ctrlEnable, ctrlFixed, 1'b0});
      REG_BASE: regRdata = listBase;
      REG_STAT: regRdata = WORD_W'(status);
      default:  regRdata = WORD_W'(intEn);
    endcase
  end

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepWord |-> (bytesLeft >= CNT_W'(BYTES_PER_WORD))); // R5
  AST_BUF_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.selBuf |-> (memAddr[1:0] == 2'b00)); // R6
  AST_STOP_CLEARS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stopEng |=> !ctrlEnable); // R8
  AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regIdx == REG_STAT && setVec == '0) |=>
      ((status & $past(regWdata[ST_W-1:0])) == '0)); // R10
endmodule

// File: rtl/dmaChainEngine.sv
module dmaChainEngine
  import dmaChainPkg::*;
#(
  parameter int SIZE_BITS = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regIdx,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memGnt,
  input  logic [31:0] memRdata,
  input  logic        fifoWrReady,
  output logic        fifoWrPush,
  output logic [31:0] fifoWrData,
  input  logic        fifoRdValid,
  output logic        fifoRdPop,
  input  logic [31:0] fifoRdData,
  output logic        irq
);
  ctlStrobe_t ctl;
  pathFlag_t flags;

  dmaChainCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .flags(flags), .memGnt(memGnt),
    .fifoWrReady(fifoWrReady), .fifoRdValid(fifoRdValid),
    .memReq(memReq), .memWe(memWe), .fifoWrPush(fifoWrPush),
    .fifoRdPop(fifoRdPop), .ctl(ctl)
  );

  dmaChainPath #(.SIZE_BITS(SIZE_BITS)) u_path (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx),
    .regWdata(regWdata), .regRdata(regRdata), .ctl(ctl), .flags(flags),
    .memRdata(memRdata), .fifoRdData(fifoRdData), .memAddr(memAddr),
    .memWdata(memWdata), .irq(irq)
  );

  assign fifoWrData = memRdata;

  AST_WBACK_DROPS_OWN: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && ctl.selWback) |-> !memWdata[BIT_OWN]); // R7
endmodule

// File: tb/test_dmaChainEngine.sv
`timescale 1ns/1ps
module test_dmaChainEngine;
  localparam int SB = 6;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] CHN = 32'h10;
  localparam logic [31:0] FST = 32'h8;
  localparam logic [31:0] LST = 32'h4;
  localparam logic [31:0] DIC = 32'h2;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regIdx = 2'd0;
  logic [31:0] regWdata = '0, regRdata;
  logic memReq, memWe, memGnt = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata;
  logic fifoWrReady = 1'b1, fifoWrPush, fifoRdValid = 1'b0, fifoRdPop;
  logic [31:0] fifoWrData, fifoRdData = '0;
  logic irq;

  dmaChainEngine #(.SIZE_BITS(SB)) i_dmaChainEngine (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memGnt(memGnt), .memRdata(memRdata),
    .fifoWrReady(fifoWrReady), .fifoWrPush(fifoWrPush), .fifoWrData(fifoWrData),
    .fifoRdValid(fifoRdValid), .fifoRdPop(fifoRdPop), .fifoRdData(fifoRdData), .irq(irq)
  );

  always #2.5 clk = ~clk;

  logic [31:0] mem [0:1023];
  assign memRdata = mem[memAddr[11:2]];

  typedef struct { bit we; logic [31:0] addr; logic [31:0] data; int req; } memItem_t;
  memItem_t expMem[$];
  logic [31:0] expPush[$];
  logic [31:0] srcQ[$];
  memItem_t monItem;
  logic [31:0] pushExp, wrA, wrD;
  bit doWr, doPop;
  int nCmp = 0, nBad = 0, gntCnt = 0;

  function automatic string tagOf(int r);
    return $sformatf("R%0d", r);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  // monitor: compares design activity against the expected queues
  always @(negedge clk) begin
    doWr = 1'b0;
    doPop = 1'b0;
    if (rstN && memReq && memGnt) begin
      if (expMem.size() == 0) chk(1'b0, "R4", "unexpected memory access", memAddr, 32'h0);
      else begin
        monItem = expMem.pop_front();
        chk(memAddr == monItem.addr && memWe == monItem.we, tagOf(monItem.req),
            "access address", memAddr, monItem.addr);
        if (monItem.we) chk(memWdata == monItem.data, tagOf(monItem.req),
                            "write data", memWdata, monItem.data);
      end
      if (memWe) begin
        doWr = 1'b1;
        wrA = memAddr;
        wrD = memWdata;
      end
    end
    if (rstN && fifoWrPush) begin
      if (expPush.size() == 0) chk(1'b0, "R4", "unexpected FIFO push", fifoWrData, 32'h0);
      else begin
        pushExp = expPush.pop_front();
        chk(fifoWrData == pushExp, "R4", "FIFO push data", fifoWrData, pushExp);
      end
    end
    if (rstN && fifoRdPop) doPop = 1'b1;
  end

  // memory, card FIFO source and grant pattern, updated after each edge
  always @(posedge clk) begin
    #1;
    if (doWr) mem[wrA[11:2]] = wrD;
    if (doPop && srcQ.size() != 0) void'(srcQ.pop_front());
    fifoRdValid = (srcQ.size() != 0);
    fifoRdData = fifoRdValid ? srcQ[0] : 32'h0;
    gntCnt++;
    memGnt = (gntCnt % 4) != 3;
  end

  task automatic regWrite(input logic [1:0] idx, input logic [31:0] d);
    @(posedge clk); #1;
    regWe = 1'b1; regIdx = idx; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] idx, output logic [31:0] d);
    @(posedge clk); #1;
    regIdx = idx;
    @(negedge clk);
    d = regRdata;
  endtask

  task automatic putDesc(input logic [31:0] a, cfg, sz, buf_a, nxt);
    mem[a[11:2]] = cfg; mem[a[11:2] + 1] = sz;
    mem[a[11:2] + 2] = buf_a; mem[a[11:2] + 3] = nxt;
  endtask

  task automatic expFetch(input logic [31:0] a, input int req);
    for (int i = 0; i < 4; i++) expMem.push_back('{1'b0, a + 32'(4 * i), 32'h0, req});
  endtask

  task automatic expOut(input logic [31:0] b, input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      mem[b[11:2] + 10'(i)] = seed + 32'(i * 7);
      expMem.push_back('{1'b0, b + 32'(4 * i), 32'h0, 4});
      expPush.push_back(seed + 32'(i * 7));
    end
  endtask

  task automatic expIn(input logic [31:0] b, input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      srcQ.push_back(seed ^ 32'(i * 13));
      expMem.push_back('{1'b1, b + 32'(4 * i), seed ^ 32'(i * 13), 4});
    end
  endtask

  task automatic expWback(input logic [31:0] a, input logic [31:0] cfg);
    expMem.push_back('{1'b1, a, cfg & ~OWN, 7}); // R7
  endtask

  task automatic waitIdle();
    logic [31:0] d;
    d = 32'h4;
    for (int n = 0; n < 3000 && d[2]; n++) regRead(2'd0, d);
    chk(d[2] == 1'b0, "R8", "engine returned to idle", d, 32'h0);
  endtask

  task automatic drained(input string tag);
    chk(expMem.size() == 0, tag, "memory accesses left over", 32'(expMem.size()), 32'h0);
    chk(expPush.size() == 0, tag, "FIFO pushes left over", 32'(expPush.size()), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 32'h0, 32'h0);
    summary();
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    regRead(2'd0, d); chk(d == 0, "R1", "control after reset", d, 0);
    regRead(2'd2, d); chk(d == 0, "R1", "status after reset", d, 0);
    regRead(2'd3, d); chk(d == 0, "R1", "int enable after reset", d, 0);
    chk(irq == 1'b0 && memReq == 1'b0, "R1", "irq/memReq after reset", {irq, memReq}, 0);

    // startup: soft reset, enables, base
    regWrite(2'd0, 32'h1);
    regWrite(2'd3, 32'h7);
    regWrite(2'd1, 32'h100);
    regRead(2'd1, d); chk(d == 32'h100, "R2", "list base readback", d, 32'h100);

    // R2/R4/R5: one memory-to-card segment, size high bits ignored
    putDesc(32'h100, OWN | LST | FST, 32'h0000_1F0C, 32'h400, 32'h0);
    expFetch(32'h100, 2);
    expOut(32'h400, 3, 32'hA000_0000);
    expWback(32'h100, OWN | LST | FST);
    regWrite(2'd0, 32'h6);
    waitIdle();
    drained("R2");
    chk(mem[32'h100 >> 2] == (LST | FST), "R7", "config rewritten", mem[32'h100 >> 2], LST | FST);
    regRead(2'd2, d); chk(d == 32'h1, "R9", "done status", d, 32'h1);
    chk(irq == 1'b1, "R10", "irq with done enabled", irq, 1);
    regRead(2'd0, d); chk(d == 32'h2, "R8", "enable cleared, fixed burst kept", d, 32'h2);
    regWrite(2'd2, 32'h1);
    regRead(2'd2, d); chk(d == 0, "R10", "status cleared by W1C", d, 0);
    chk(irq == 1'b0, "R10", "irq dropped", irq, 0);

    // R8/R5/R4: card-to-memory chain, chained jump then sequential, max segment
    putDesc(32'h200, OWN | CHN | DIC | FST, 32'h8, 32'h600, 32'h300);
    putDesc(32'h300, OWN | DIC, 32'h40, 32'h700, 32'hABC0);
    putDesc(32'h310, OWN | LST, 32'h4, 32'h800, 32'h0);
    expFetch(32'h200, 2);
    expIn(32'h600, 2, 32'h1111_0000);
    expWback(32'h200, OWN | CHN | DIC | FST);
    expFetch(32'h300, 8);
    expIn(32'h700, 16, 32'h2222_0000);
    expWback(32'h300, OWN | DIC);
    expFetch(32'h310, 8);
    expIn(32'h800, 1, 32'h3333_0000);
    expWback(32'h310, OWN | LST);
    regWrite(2'd1, 32'h200);
    regWrite(2'd0, 32'hE);
    waitIdle();
    drained("R8");
    chk(srcQ.size() == 0, "R4", "card FIFO drained", 32'(srcQ.size()), 0);
    regRead(2'd2, d); chk(d == 32'h1, "R9", "done after chain", d, 32'h1);
    regWrite(2'd2, 32'h7);

    // R9: suppressed completion on the last descriptor
    putDesc(32'h380, OWN | LST | DIC, 32'h4, 32'h480, 32'h0);
    expFetch(32'h380, 2);
    expOut(32'h480, 1, 32'h5A5A_0000);
    expWback(32'h380, OWN | LST | DIC);
    regWrite(2'd1, 32'h380);
    regWrite(2'd0, 32'h6);
    waitIdle();
    drained("R9");
    regRead(2'd2, d); chk(d == 0, "R9", "no done when suppressed", d, 0);
    chk(irq == 1'b0, "R9", "irq stays low", irq, 0);

    // R3: descriptor not owned
    putDesc(32'h3C0, LST, 32'h8, 32'h900, 32'h0);
    expFetch(32'h3C0, 3);
    regWrite(2'd1, 32'h3C0);
    regWrite(2'd0, 32'h6);
    waitIdle();
    drained("R3");
    regRead(2'd2, d); chk(d == 32'h2, "R3", "unavailable status", d, 32'h2);
    chk(irq == 1'b1, "R3", "irq on unavailable", irq, 1);
    chk(mem[32'h3C0 >> 2] == LST, "R3", "config untouched", mem[32'h3C0 >> 2], LST);
    regWrite(2'd2, 32'h2);

    // R6: misaligned buffer, then misaligned length
    putDesc(32'h3C0, OWN | LST, 32'h8, 32'h902, 32'h0);
    expFetch(32'h3C0, 6);
    regWrite(2'd0, 32'h6);
    waitIdle();
    drained("R6");
    regRead(2'd2, d); chk(d == 32'h4, "R6", "alignment status (buffer)", d, 32'h4);
    chk(mem[32'h3C0 >> 2] == (OWN | LST), "R6", "no write-back", mem[32'h3C0 >> 2], OWN | LST);
    regWrite(2'd2, 32'h4);
    putDesc(32'h3C0, OWN | LST, 32'h6, 32'h900, 32'h0);
    expFetch(32'h3C0, 6);
    regWrite(2'd0, 32'h6);
    waitIdle();
    drained("R6");
    regRead(2'd2, d); chk(d == 32'h4, "R6", "alignment status (length)", d, 32'h4);

    // R11: soft reset during a stalled segment
    fifoWrReady = 1'b0;
    putDesc(32'h3E0, OWN | LST, 32'h8, 32'h400, 32'h0);
    expFetch(32'h3E0, 11);
    regWrite(2'd1, 32'h3E0);
    regWrite(2'd0, 32'h6);
    repeat (20) @(posedge clk);
    regRead(2'd0, d); chk(d[2] == 1'b1, "R11", "engine still running", d, 32'h6);
    regWrite(2'd0, 32'h1);
    regRead(2'd0, d); chk(d == 0, "R11", "control after soft reset", d, 0);
    regRead(2'd2, d); chk(d == 0, "R11", "status after soft reset", d, 0);
    fifoWrReady = 1'b1;
    repeat (20) @(posedge clk);
    drained("R11");
    chk(mem[32'h3E0 >> 2] == (OWN | LST), "R11", "aborted descriptor kept", mem[32'h3E0 >> 2], OWN | LST);

    // R11: restart after soft reset
    putDesc(32'h100, OWN | LST, 32'h4, 32'h440, 32'h0);
    expFetch(32'h100, 11);
    expOut(32'h440, 1, 32'hC0DE_0000);
    expWback(32'h100, OWN | LST);
    regWrite(2'd1, 32'h100);
    regWrite(2'd0, 32'h6);
    waitIdle();
    drained("R11");
    regRead(2'd2, d); chk(d == 32'h1, "R11", "done after restart", d, 32'h1);

    summary();
  end
endmodule